// File: doc/BRIEF.md
# Receive FIFO with Error Summary

This block buffers received UART characters between a serial receiver and a host. Each stored byte carries three error tags: a parity error, a framing error and a break condition. The receiver writes a byte and its tags through a push strobe. The host reads the oldest byte through a pop strobe. The oldest byte and its three tags are always presented together on the head outputs.

Besides the per-byte tags, the block keeps one summary flag. The flag is set while any byte still held in the FIFO carries any error tag, not only the byte at the head. It is kept exact by counting the tagged entries. A tagged push increments the count, a tagged pop decrements it, and a push and pop in the same cycle are netted.

A push into a full FIFO is discarded and sets a sticky overrun flag, which the host clears with a status-read strobe. A synchronous flush empties the whole store in one cycle.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the FIFO is empty (empty_o=1, full_o=0, level_o=0), err_any_o=0, overrun_o=0, and the head data and tags read 0.
- R2: Bytes leave in the order they were accepted. head_data_o shows the oldest stored byte, and level_o counts the stored bytes. All outputs update on the clock edge that samples the strobe.
- R3: head_par_o, head_frm_o and head_brk_o show the parity, framing and break tags that were pushed with the current head byte.
- R4: err_any_o is 1 exactly when at least one stored entry has any of its three tags set, and it is 0 whenever the FIFO is empty.
- R5: While an errored entry remains anywhere in the FIFO, err_any_o stays 1, even when the head entry is clean. It falls only on the pop that removes the last errored entry.
- R6: A push and a pop in the same cycle on a non-empty, non-full FIFO leave level_o unchanged. The errored-entry tracking reflects both the incoming and the departing entry.
- R7: A push while full_o=1 (DEPTH entries, default 16) is discarded, even if a pop occurs in the same cycle. The stored contents and err_any_o are not affected by the discarded byte.
- R8: A discarded push sets overrun_o on the next edge. overrun_o stays set until a cycle with stat_rd_i=1 and no new overrun, which clears it. A new overrun in the same cycle as stat_rd_i keeps it set.
- R9: flush_i=1 empties the FIFO in one cycle. It clears the stored data and tags, the errored-entry count and err_any_o, and it takes priority over a push or a pop in the same cycle. It does not change overrun_o.
- R10: A pop while the FIFO is empty has no effect on level_o, err_any_o or the following push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Synchronous FIFO clear |
| push_i | input | 1 | Write strobe from receiver |
| push_data_i | input | DATA_W | Received byte |
| push_par_i | input | 1 | Parity error tag of pushed byte |
| push_frm_i | input | 1 | Framing error tag of pushed byte |
| push_brk_i | input | 1 | Break tag of pushed byte |
| pop_i | input | 1 | Host read strobe |
| stat_rd_i | input | 1 | Host status read, clears overrun |
| head_data_o | output | DATA_W | Oldest stored byte |
| head_par_o | output | 1 | Parity tag of head byte |
| head_frm_o | output | 1 | Framing tag of head byte |
| head_brk_o | output | 1 | Break tag of head byte |
| empty_o | output | 1 | FIFO holds no entry |
| full_o | output | 1 | FIFO holds DEPTH entries |
| level_o | output | $clog2(DEPTH+1) | Number of stored entries |
| err_any_o | output | 1 | Some stored entry carries an error tag |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The hardest state to reach is a FIFO that is full and holds an errored entry buried behind clean ones. In that state a discarded errored push must neither raise the count nor let the flag drop early. The bench fills all sixteen slots with a tagged byte in the middle and pushes a tagged byte into the full FIFO, alone and together with a pop and a status read. It then drains the FIFO and watches the flag stay high past several clean heads. Simultaneous push and pop is driven with all four clean/errored pairings, and a flush is issued together with a push to show its priority.

// File: rtl/rx_err_fifo_pkg.sv
package rx_err_fifo_pkg;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } err_tag_t;

  function automatic logic tag_hit(err_tag_t t);
    return t.brk | t.frm | t.par;
  endfunction

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_err_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  err_tag_t          wr_tag_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output err_tag_t          rd_tag_o,
  output logic [LVL_W-1:0]  level_o
);

  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0]  level_q;
  logic [DATA_W-1:0] data_q [DEPTH];
  err_tag_t          tag_q  [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[i] <= '0;
        tag_q[i]  <= '0;
      end else if (flush_i) begin
        data_q[i] <= '0;
        tag_q[i]  <= '0;
      end else if (wr_i && wr_ptr_q == PTR_W'(i)) begin
        data_q[i] <= wr_data_i;
        tag_q[i]  <= wr_tag_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_i) rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({wr_i, rd_i})
        2'b10:   level_q <= level_q + LVL_W'(1);
        2'b01:   level_q <= level_q - LVL_W'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  assign rd_data_o = data_q[rd_ptr_q];
  assign rd_tag_o  = tag_q[rd_ptr_q];
  assign level_o   = level_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_W'(DEPTH)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == LVL_W'(DEPTH)) |-> !(wr_i && !rd_i)); // R7
  AST_NO_UNDERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == '0) |-> !rd_i); // R10

endmodule

// File: rtl/rx_err_counter.sv
module rx_err_counter #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             any_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (flush_i)  cnt_q <= '0;
    else begin
      case ({inc_i, dec_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
  assign any_o = (cnt_q != '0);

  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> !(dec_i && !inc_i)); // R5
  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(DEPTH)) |-> !(inc_i && !dec_i)); // R7
  AST_FLUSH_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/rx_ovr_flag.sv
module rx_ovr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;  // set wins over clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q); // R8
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q); // R8

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rx_err_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              push_par_i,
  input  logic              push_frm_i,
  input  logic              push_brk_i,
  input  logic              pop_i,
  input  logic              stat_rd_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic              head_par_o,
  output logic              head_frm_o,
  output logic              head_brk_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              err_any_o,
  output logic              overrun_o
);

  err_tag_t          push_tag, head_tag;
  logic [LVL_W-1:0]  level;
  logic [LVL_W-1:0]  err_cnt;
  logic              full, empty;
  logic              wr_ok, rd_ok, ovr_set;

  assign push_tag = '{brk: push_brk_i, frm: push_frm_i, par: push_par_i};
  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);
  // full check ignores same-cycle pop: a push at full is always discarded
  assign wr_ok    = push_i && !full && !flush_i;
  assign rd_ok    = pop_i && !empty && !flush_i;
  assign ovr_set  = push_i && full && !flush_i;

  rx_fifo_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .wr_i      (wr_ok),
    .wr_data_i (push_data_i),
    .wr_tag_i  (push_tag),
    .rd_i      (rd_ok),
    .rd_data_o (head_data_o),
    .rd_tag_o  (head_tag),
    .level_o   (level)
  );

  rx_err_counter #(
    .DEPTH (DEPTH)
  ) i_err_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .inc_i   (wr_ok && tag_hit(push_tag)),
    .dec_i   (rd_ok && tag_hit(head_tag)),
    .cnt_o   (err_cnt),
    .any_o   (err_any_o)
  );

  rx_ovr_flag i_ovr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovr_set),
    .clr_i  (stat_rd_i),
    .flag_o (overrun_o)
  );

  assign head_par_o = head_tag.par;
  assign head_frm_o = head_tag.frm;
  assign head_brk_o = head_tag.brk;
  assign empty_o    = empty;
  assign full_o     = full;
  assign level_o    = level;

  AST_ERR_LE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt <= level); // R4
  AST_EMPTY_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> !err_any_o); // R4
  AST_HEAD_ERR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty && tag_hit(head_tag)) |-> err_any_o); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (empty && !err_any_o)); // R9
  AST_PUSH_POP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && rd_ok) |=> $stable(level)); // R6

endmodule

// File: tb/test_rx_err_fifo.sv
`timescale 1ns/1ps
module test_rx_err_fifo;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush = 0, push = 0, pop = 0, stat_rd = 0;
  logic [DATA_W-1:0] pdata = '0;
  logic              ppar = 0, pfrm = 0, pbrk = 0;
  logic [DATA_W-1:0] hdata;
  logic              hpar, hfrm, hbrk, empty, full, err_any, ovr;
  logic [LVL_W-1:0]  level;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [DATA_W+2:0] q[$];  // {brk,frm,par,data}
  bit m_ovr = 0;

  always #2.5 clk = ~clk;

  rx_err_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rx_err_fifo (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .push_i(push),
    .push_data_i(pdata), .push_par_i(ppar), .push_frm_i(pfrm), .push_brk_i(pbrk),
    .pop_i(pop), .stat_rd_i(stat_rd), .head_data_o(hdata), .head_par_o(hpar),
    .head_frm_o(hfrm), .head_brk_o(hbrk), .empty_o(empty), .full_o(full),
    .level_o(level), .err_any_o(err_any), .overrun_o(ovr));

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit model_any();
    foreach (q[i]) if (q[i][DATA_W+2:DATA_W] != 3'b000) return 1;
    return 0;
  endfunction

  task automatic check_state(string req);
    chk(req, "level", int'(level), q.size());
    chk(req, "empty", int'(empty), int'(q.size() == 0));
    chk(req, "full", int'(full), int'(q.size() == DEPTH));
    chk(req, "err_any", int'(err_any), int'(model_any()));
    chk(req, "overrun", int'(ovr), int'(m_ovr));
    if (q.size() != 0) begin
      chk(req, "head_data", int'(hdata), int'(q[0][DATA_W-1:0]));
      chk(req, "head_tags", int'({hbrk, hfrm, hpar}), int'(q[0][DATA_W+2:DATA_W]));
    end
  endtask

  // One cycle: drive at negedge, model updates at the edge, compare at next negedge
  task automatic cyc(bit do_push, logic [DATA_W-1:0] d, logic [2:0] tags,
                     bit do_pop, bit do_rd, bit do_flush, string req);
    int sz;
    push = do_push; pdata = d; {pbrk, pfrm, ppar} = tags;
    pop = do_pop; stat_rd = do_rd; flush = do_flush;
    @(posedge clk);
    sz = q.size();
    if (do_flush) q.delete();
    else begin
      if (do_pop && sz > 0) void'(q.pop_front());
      if (do_push && sz < DEPTH) q.push_back({tags, d});
    end
    if (do_push && sz == DEPTH && !do_flush) m_ovr = 1;
    else if (do_rd) m_ovr = 0;
    @(negedge clk);
    push = 0; pop = 0; stat_rd = 0; flush = 0; {pbrk, pfrm, ppar} = 3'b000;
    check_state(req);
  endtask

  task automatic t_reset();
    chk("R1", "level", int'(level), 0);
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "full", int'(full), 0);
    chk("R1", "err_any", int'(err_any), 0);
    chk("R1", "overrun", int'(ovr), 0);
    chk("R1", "head", int'({hbrk, hfrm, hpar, hdata}), 0);
  endtask

  task automatic t_order();
    cyc(1, 8'hA1, 3'b000, 0, 0, 0, "R2");
    cyc(1, 8'hB2, 3'b000, 0, 0, 0, "R2");
    cyc(1, 8'hC3, 3'b001, 0, 0, 0, "R3");
    cyc(1, 8'hD4, 3'b010, 0, 0, 0, "R3");
    cyc(1, 8'hE5, 3'b100, 0, 0, 0, "R3");
    for (int i = 0; i < 5; i++) cyc(0, '0, 3'b000, 1, 0, 0, "R2_R3");
  endtask

  task automatic t_summary();
    cyc(1, 8'h11, 3'b000, 0, 0, 0, "R4");
    cyc(1, 8'h22, 3'b010, 0, 0, 0, "R4");
    cyc(1, 8'h33, 3'b000, 0, 0, 0, "R5");
    cyc(1, 8'h44, 3'b000, 0, 0, 0, "R5");
    cyc(1, 8'h55, 3'b100, 0, 0, 0, "R5");
    cyc(1, 8'h66, 3'b000, 0, 0, 0, "R5");
    cyc(0, '0, 3'b000, 1, 0, 0, "R5");  // clean head out, errors remain
    cyc(0, '0, 3'b000, 1, 0, 0, "R5");  // framing entry out, break remains
    cyc(0, '0, 3'b000, 1, 0, 0, "R5");
    chk("R5", "err_any behind clean head", int'(err_any), 1);
    cyc(0, '0, 3'b000, 1, 0, 0, "R5");
    cyc(0, '0, 3'b000, 1, 0, 0, "R5");  // last errored entry leaves
    chk("R5", "err_any after last errored pop", int'(err_any), 0);
    cyc(0, '0, 3'b000, 1, 0, 0, "R4");
  endtask

  task automatic t_simul();
    cyc(1, 8'h01, 3'b000, 0, 0, 0, "R6");
    cyc(1, 8'h02, 3'b001, 1, 0, 0, "R6");  // errored in, clean out
    cyc(1, 8'h03, 3'b000, 1, 0, 0, "R6");  // clean in, errored out
    cyc(1, 8'h04, 3'b110, 0, 0, 0, "R6");
    cyc(1, 8'h05, 3'b010, 1, 0, 0, "R6");  // clean out, errored in
    cyc(1, 8'h06, 3'b100, 1, 0, 0, "R6");  // errored out, errored in
    cyc(1, 8'h07, 3'b000, 1, 0, 0, "R6");  // errored out, clean in
    chk("R6", "level after paired ops", int'(level), 2);
    cyc(0, '0, 3'b000, 1, 0, 0, "R6");
    cyc(0, '0, 3'b000, 1, 0, 0, "R6");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++)
      cyc(1, 8'(8'h40 + i), (i == 5) ? 3'b001 : 3'b000, 0, 0, 0, "R7");
    chk("R7", "full", int'(full), 1);
    cyc(1, 8'hEE, 3'b100, 0, 0, 0, "R7");  // dropped
    chk("R8", "overrun set", int'(ovr), 1);
    cyc(0, '0, 3'b000, 0, 0, 0, "R8");     // sticky
    cyc(1, 8'hEF, 3'b010, 0, 1, 0, "R8");  // set wins over clear
    cyc(0, '0, 3'b000, 0, 1, 0, "R8");     // clear
    chk("R8", "overrun cleared", int'(ovr), 0);
    cyc(1, 8'hF0, 3'b001, 1, 0, 0, "R7");  // full: push dropped even with pop
    chk("R7", "level after pop with dropped push", int'(level), DEPTH - 1);
    cyc(0, '0, 3'b000, 0, 1, 0, "R8");
    while (q.size() > 0) cyc(0, '0, 3'b000, 1, 0, 0, "R7");
  endtask

  task automatic t_flush();
    cyc(1, 8'h5A, 3'b101, 0, 0, 0, "R9");
    cyc(1, 8'h6B, 3'b000, 0, 0, 0, "R9");
    m_ovr = m_ovr;
    cyc(1, 8'h7C, 3'b010, 0, 0, 1, "R9");  // flush beats push
    chk("R9", "head data cleared", int'({hbrk, hfrm, hpar, hdata}), 0);
    cyc(1, 8'h8D, 3'b000, 0, 0, 0, "R9");
    cyc(0, '0, 3'b000, 1, 0, 0, "R9");
  endtask

  task automatic t_flush_ovr();
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i), 3'b000, 0, 0, 0, "R9");
    cyc(1, 8'hAA, 3'b000, 0, 0, 0, "R9");  // overrun
    cyc(0, '0, 3'b000, 0, 0, 1, "R9");     // flush keeps overrun
    chk("R9", "overrun kept by flush", int'(ovr), 1);
    cyc(0, '0, 3'b000, 0, 1, 0, "R8");
  endtask

  task automatic t_pop_empty();
    cyc(0, '0, 3'b000, 1, 0, 0, "R10");
    cyc(0, '0, 3'b000, 1, 0, 0, "R10");
    cyc(1, 8'h99, 3'b010, 0, 0, 0, "R10");
    cyc(1, 8'h9A, 3'b000, 0, 0, 0, "R10");
    cyc(0, '0, 3'b000, 1, 0, 0, "R10");
    cyc(0, '0, 3'b000, 1, 0, 0, "R10");
    cyc(0, '0, 3'b000, 1, 0, 0, "R10");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_summary();
    t_simul();
    t_full();
    t_flush();
    t_flush_ovr();
    t_pop_empty();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule